// File: doc/BRIEF.md
# Legacy Virtio Register Window

This block is the I/O register window of a legacy virtio device. Software reaches it through byte-addressed reads and writes that carry a size field. The window holds the negotiated guest feature word, the queue selector and a page number for each queue. It also holds the device status byte and the pending interrupt causes. The queue depth is fixed by a parameter and can be read back. Writes produce one-cycle pulses to the rest of the device: ring set-up for a queue, device reset, driver-ready and queue service. Ring engines watch these pulses.

Accesses at or above the device-specific region are handed to a separate config port and held there until that port acknowledges. A three-state access machine sequences every access:
- **IDLE** accepts an access.
- **IDLE → RESP** is taken on a read of a common register.
- **IDLE → CFG_WAIT** is taken on any access at or above the device-specific region.
- **CFG_WAIT** holds the forwarded request until the config port acknowledges. It then goes **CFG_WAIT → RESP** for a read or **CFG_WAIT → IDLE** for a write.
- **RESP → IDLE** is always taken after one cycle of read data.

Writes to common registers complete in IDLE without a state change. Every output pulse appears in the cycle after the access is accepted.

Top module: `vio_regwin`

## Requirements
- R1: After reset the block is ready, `irq_o` and all pulses are low, and the guest features, queue selector, status, ISR and every queue page number read back as zero.
- R2: A read of offset 0 returns the host feature parameter ORed with bit 24 (notify-on-empty) and bit 30 (bad-feature).
- R3: A write to offset 4 stores the minimal feature parameter when bit 30 is set. Otherwise it stores the full host set (host parameter OR bit 24) when any bit outside that set is requested, and otherwise the written word unchanged. Offset 4 reads back the stored word.
- R4: A write to offset 14 changes the queue selector only when its low 16 bits are below NUM_QUEUES; any other value leaves the selector unchanged. Offset 14 reads back the selector.
- R5: A nonzero write to offset 8 stores the page number for the selected queue and pulses `qinit_o` with `qinit_idx_o` set to that queue. Offset 8 reads back the selected queue's page number, and offset 12 returns QUEUE_DEPTH.
- R6: A write of zero to offset 8, or a write whose low byte is zero to offset 18, pulses `dev_reset_o` and clears the guest features, selector, status, ISR and every page number.
- R7: Offset 18 holds the status byte. A nonzero write that sets bit 2 (driver-ok) while the stored bit 2 is clear pulses `drv_ready_o`; a write that leaves bit 2 set does not.
- R8: A write to offset 16 pulses `notify_o` with `notify_idx_o` set to the written queue number only when that number is below NUM_QUEUES and that queue's page number is nonzero.
- R9: Cause bits on `irq_cause_i` accumulate in the ISR, and `irq_o` is high while the ISR is nonzero. A read of offset 19 returns the pending bits, clears them and drops `irq_o`. A cause arriving in the cycle of that read stays pending.
- R10: An access at offset 20 or above raises `cfg_req_o` with the offset minus 20, the size, the write flag and the data, and holds them until `cfg_ack_i`. A read then returns `cfg_rdata_i` as captured at the acknowledge.
- R11: A read of an unused offset below 20 returns all ones, and a write there changes no register.
- R12: `acc_ready_o` is high only in IDLE. A read of a common register gives `acc_rvalid_o` for exactly the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte offset in the window |
| acc_size_i | input | 2 | Access size code, forwarded to the config port |
| acc_wdata_i | input | 32 | Write data |
| acc_ready_o | output | 1 | Window can accept an access |
| acc_rvalid_o | output | 1 | Read data valid |
| acc_rdata_o | output | 32 | Read data |
| irq_cause_i | input | 8 | Interrupt cause bits to add to the ISR |
| irq_o | output | 1 | Interrupt line |
| qinit_o | output | 1 | Ring set-up pulse |
| qinit_idx_o | output | QI_W | Queue for the ring set-up pulse |
| notify_o | output | 1 | Queue service pulse |
| notify_idx_o | output | QI_W | Queue to service |
| dev_reset_o | output | 1 | Device reset pulse |
| drv_ready_o | output | 1 | Driver-ready pulse |
| cfg_req_o | output | 1 | Config port request, held until acknowledged |
| cfg_write_o | output | 1 | Config port write flag |
| cfg_addr_o | output | ADDR_W | Offset within the device config region |
| cfg_size_o | output | 2 | Config access size code |
| cfg_wdata_o | output | 32 | Config write data |
| cfg_ack_i | input | 1 | Config port acknowledge |
| cfg_rdata_i | input | 32 | Config read data |

## Verification
The assertions check several properties on every cycle:
- the selector always stays in range;
- the stored feature word is never a value outside the host set other than the minimal set;
- a reset pulse always coincides with cleared registers;
- an ISR read always leaves only the causes that arrived with it;
- a forwarded config request stays stable until acknowledged;
- read data comes exactly one cycle after acceptance.

Only the bench scenarios can show the returned values themselves:
- the three outcomes of feature vetting;
- the page-number-gated notify after a reset;
- driver-ok firing only on its first rising write;
- unused offsets reading all ones without side effects.

// File: rtl/vio_regwin_pkg.sv
package vio_regwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESP,
        ST_CFG_WAIT
    } acc_state_e;

    localparam int unsigned OFS_HOSTF  = 0;
    localparam int unsigned OFS_GUESTF = 4;
    localparam int unsigned OFS_QPFN   = 8;
    localparam int unsigned OFS_QSIZE  = 12;
    localparam int unsigned OFS_QSEL   = 14;
    localparam int unsigned OFS_NOTIFY = 16;
    localparam int unsigned OFS_STATUS = 18;
    localparam int unsigned OFS_ISR    = 19;
    localparam int unsigned OFS_CFG    = 20;

    localparam int unsigned FBIT_EMPTY_NOTE = 24;
    localparam int unsigned FBIT_BAD        = 30;
    localparam int unsigned SBIT_DRV_OK     = 2;

endpackage

// File: rtl/vio_feat_vet.sv
module vio_feat_vet
    import vio_regwin_pkg::*;
#(
    parameter logic [31:0] HOST_FEAT = 32'h0000_0021,
    parameter logic [31:0] MIN_FEAT  = 32'h0000_0001
) (
    input  logic [31:0] req_i,
    output logic [31:0] host_full_o,
    output logic [31:0] host_read_o,
    output logic [31:0] grant_o
);
    assign host_full_o = HOST_FEAT | (32'd1 << FBIT_EMPTY_NOTE);
    assign host_read_o = host_full_o | (32'd1 << FBIT_BAD);

    always_comb begin
        if (req_i[FBIT_BAD])
            grant_o = MIN_FEAT;
        else if (|(req_i & ~host_full_o))
            grant_o = host_full_o;
        else
            grant_o = req_i;
    end
endmodule

// File: rtl/vio_queue_bank.sv
module vio_queue_bank #(
    parameter int NUM_QUEUES = 2,
    parameter int PFN_W      = 32,
    parameter int QI_W       = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [QI_W-1:0]  wr_idx_i,
    input  logic [PFN_W-1:0] wr_pfn_i,
    input  logic [QI_W-1:0]  rd_idx_i,
    output logic [PFN_W-1:0] rd_pfn_o,
    input  logic [QI_W-1:0]  probe_idx_i,
    output logic             probe_live_o
);
    logic [PFN_W-1:0] pfn_q [NUM_QUEUES];

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pfn_q[q] <= '0;
            else if (flush_i)
                pfn_q[q] <= '0;
            else if (wr_en_i && wr_idx_i == QI_W'(q))
                pfn_q[q] <= wr_pfn_i;
        end
    end

    always_comb begin
        rd_pfn_o     = '0;
        probe_live_o = 1'b0;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            if (rd_idx_i == QI_W'(q))
                rd_pfn_o = pfn_q[q];
            if (probe_idx_i == QI_W'(q))
                probe_live_o = (pfn_q[q] != '0);
        end
    end
endmodule

// File: rtl/vio_isr_ctl.sv
module vio_isr_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] raise_i,
    input  logic       take_i,
    input  logic       flush_i,
    output logic [7:0] isr_o,
    output logic       irq_o
);
    logic [7:0] isr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            isr_q <= '0;
        else if (flush_i)
            isr_q <= '0;
        else
            isr_q <= (take_i ? 8'h00 : isr_q) | raise_i;
    end

    assign isr_o = isr_q;
    assign irq_o = |isr_q;

    a_r9_take_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !flush_i |=> isr_q == $past(raise_i));
endmodule

// File: rtl/vio_regwin.sv
module vio_regwin
    import vio_regwin_pkg::*;
#(
    parameter int          NUM_QUEUES  = 2,
    parameter int          QUEUE_DEPTH = 256,
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] HOST_FEAT   = 32'h0000_0021,
    parameter logic [31:0] MIN_FEAT    = 32'h0000_0001,
    localparam int         QI_W        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_size_i,
    input  logic [31:0]       acc_wdata_i,
    output logic              acc_ready_o,
    output logic              acc_rvalid_o,
    output logic [31:0]       acc_rdata_o,
    input  logic [7:0]        irq_cause_i,
    output logic              irq_o,
    output logic              qinit_o,
    output logic [QI_W-1:0]   qinit_idx_o,
    output logic              notify_o,
    output logic [QI_W-1:0]   notify_idx_o,
    output logic              dev_reset_o,
    output logic              drv_ready_o,
    output logic              cfg_req_o,
    output logic              cfg_write_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic [1:0]        cfg_size_o,
    output logic [31:0]       cfg_wdata_o,
    input  logic              cfg_ack_i,
    input  logic [31:0]       cfg_rdata_i
);
    acc_state_e state_q, state_d;

    logic [31:0]     guest_q;
    logic [QI_W-1:0] sel_q;
    logic [7:0]      status_q;
    logic [31:0]     rdata_q;
    logic [31:0]     rd_mux;
    logic            cfg_write_q;

    logic [31:0] host_full, host_read, feat_grant;
    logic [31:0] sel_pfn;
    logic [7:0]  isr;
    logic        notify_live;

    logic accept, is_cfg, wr, rd;
    logic hit_hostf, hit_guestf, hit_qpfn, hit_qsize, hit_qsel, hit_notify, hit_status, hit_isr;
    logic soft_rst, pfn_set, sel_ok, notify_fire, ready_fire, isr_take;
    logic [15:0] q_num;

    assign accept     = acc_valid_i && (state_q == ST_IDLE);
    assign is_cfg     = acc_addr_i >= ADDR_W'(OFS_CFG);
    assign wr         = accept && acc_write_i && !is_cfg;
    assign rd         = accept && !acc_write_i && !is_cfg;
    assign hit_hostf  = acc_addr_i == ADDR_W'(OFS_HOSTF);
    assign hit_guestf = acc_addr_i == ADDR_W'(OFS_GUESTF);
    assign hit_qpfn   = acc_addr_i == ADDR_W'(OFS_QPFN);
    assign hit_qsize  = acc_addr_i == ADDR_W'(OFS_QSIZE);
    assign hit_qsel   = acc_addr_i == ADDR_W'(OFS_QSEL);
    assign hit_notify = acc_addr_i == ADDR_W'(OFS_NOTIFY);
    assign hit_status = acc_addr_i == ADDR_W'(OFS_STATUS);
    assign hit_isr    = acc_addr_i == ADDR_W'(OFS_ISR);

    assign q_num       = acc_wdata_i[15:0];
    assign sel_ok      = q_num < 16'(NUM_QUEUES);
    assign soft_rst    = wr && ((hit_qpfn && acc_wdata_i == 32'd0) ||
                                (hit_status && acc_wdata_i[7:0] == 8'd0));
    assign pfn_set     = wr && hit_qpfn && acc_wdata_i != 32'd0;
    assign notify_fire = wr && hit_notify && sel_ok && notify_live;
    assign ready_fire  = wr && hit_status && acc_wdata_i[7:0] != 8'd0 &&
                         acc_wdata_i[SBIT_DRV_OK] && !status_q[SBIT_DRV_OK];
    assign isr_take    = rd && hit_isr;

    vio_feat_vet #(.HOST_FEAT(HOST_FEAT), .MIN_FEAT(MIN_FEAT)) u_vet (
        .req_i       (acc_wdata_i),
        .host_full_o (host_full),
        .host_read_o (host_read),
        .grant_o     (feat_grant)
    );

    vio_queue_bank #(.NUM_QUEUES(NUM_QUEUES), .PFN_W(32), .QI_W(QI_W)) u_qbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (soft_rst),
        .wr_en_i      (pfn_set),
        .wr_idx_i     (sel_q),
        .wr_pfn_i     (acc_wdata_i),
        .rd_idx_i     (sel_q),
        .rd_pfn_o     (sel_pfn),
        .probe_idx_i  (q_num[QI_W-1:0]),
        .probe_live_o (notify_live)
    );

    vio_isr_ctl u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (irq_cause_i),
        .take_i  (isr_take),
        .flush_i (soft_rst),
        .isr_o   (isr),
        .irq_o   (irq_o)
    );

    // Access sequencing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_cfg)
                    state_d = ST_CFG_WAIT;
                else if (accept && !acc_write_i)
                    state_d = ST_RESP;
            end
            ST_RESP:     state_d = ST_IDLE;
            ST_CFG_WAIT: begin
                if (cfg_ack_i)
                    state_d = cfg_write_q ? ST_IDLE : ST_RESP;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        if (hit_hostf)       rd_mux = host_read;
        else if (hit_guestf) rd_mux = guest_q;
        else if (hit_qpfn)   rd_mux = sel_pfn;
        else if (hit_qsize)  rd_mux = 32'(QUEUE_DEPTH);
        else if (hit_qsel)   rd_mux = 32'(sel_q);
        else if (hit_status) rd_mux = {24'd0, status_q};
        else if (hit_isr)    rd_mux = {24'd0, isr};
        else                 rd_mux = '1;
    end

    // Registers, read data, forwarded request and pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guest_q      <= '0;
            sel_q        <= '0;
            status_q     <= '0;
            rdata_q      <= '0;
            cfg_write_q  <= 1'b0;
            cfg_addr_o   <= '0;
            cfg_size_o   <= '0;
            cfg_wdata_o  <= '0;
            qinit_o      <= 1'b0;
            qinit_idx_o  <= '0;
            notify_o     <= 1'b0;
            notify_idx_o <= '0;
            dev_reset_o  <= 1'b0;
            drv_ready_o  <= 1'b0;
        end else begin
            if (soft_rst) begin
                guest_q  <= '0;
                sel_q    <= '0;
                status_q <= '0;
            end else if (wr) begin
                if (hit_guestf)           guest_q  <= feat_grant;
                if (hit_qsel && sel_ok)   sel_q    <= q_num[QI_W-1:0];
                if (hit_status)           status_q <= acc_wdata_i[7:0];
            end
            if (rd)
                rdata_q <= rd_mux;
            else if (state_q == ST_CFG_WAIT && cfg_ack_i && !cfg_write_q)
                rdata_q <= cfg_rdata_i;
            if (accept && is_cfg) begin
                cfg_write_q <= acc_write_i;
                cfg_addr_o  <= acc_addr_i - ADDR_W'(OFS_CFG);
                cfg_size_o  <= acc_size_i;
                cfg_wdata_o <= acc_wdata_i;
            end
            qinit_o      <= pfn_set;
            qinit_idx_o  <= sel_q;
            notify_o     <= notify_fire;
            notify_idx_o <= q_num[QI_W-1:0];
            dev_reset_o  <= soft_rst;
            drv_ready_o  <= ready_fire;
        end
    end

    assign acc_ready_o  = (state_q == ST_IDLE);
    assign acc_rvalid_o = (state_q == ST_RESP);
    assign acc_rdata_o  = rdata_q;
    assign cfg_req_o    = (state_q == ST_CFG_WAIT);
    assign cfg_write_o  = cfg_write_q;

    a_r12_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> acc_rvalid_o && !acc_ready_o);
    a_r4_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NUM_QUEUES);
    a_r3_guest_vetted: assert property (@(posedge clk) disable iff (!rst_n)
        ((guest_q & ~host_full) == 32'd0) || (guest_q == MIN_FEAT));
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_o |-> guest_q == 32'd0 && status_q == 8'd0 && isr == 8'd0 && sel_q == '0);
    a_r7_ready_not_reset: assert property (@(posedge clk) disable iff (!rst_n)
        drv_ready_o |-> !dev_reset_o && status_q[SBIT_DRV_OK]);
    a_r8_notify_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |-> $past(wr && hit_notify));
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_wdata_o));
endmodule

// File: tb/vio_regwin_bench.sv
module vio_regwin_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 2;
    localparam logic [31:0] HOSTF = 32'h0000_0021;
    localparam logic [31:0] MINF  = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, acc_rvalid;
    logic [31:0] acc_rdata;
    logic [7:0]  irq_cause = '0;
    logic        irq;
    logic        qinit, notify, dev_reset, drv_ready;
    logic [0:0]  qinit_idx, notify_idx;
    logic        cfg_req, cfg_write;
    logic [7:0]  cfg_addr;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic p_qinit, p_notify, p_rst, p_rdy;
    logic [0:0] p_qidx, p_nidx;

    vio_regwin #(.NUM_QUEUES(NQ), .QUEUE_DEPTH(256), .ADDR_W(8),
                 .HOST_FEAT(HOSTF), .MIN_FEAT(MINF)) u_vio_regwin (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
        .acc_size_i(acc_size), .acc_wdata_i(acc_wdata),
        .acc_ready_o(acc_ready), .acc_rvalid_o(acc_rvalid), .acc_rdata_o(acc_rdata),
        .irq_cause_i(irq_cause), .irq_o(irq),
        .qinit_o(qinit), .qinit_idx_o(qinit_idx),
        .notify_o(notify), .notify_idx_o(notify_idx),
        .dev_reset_o(dev_reset), .drv_ready_o(drv_ready),
        .cfg_req_o(cfg_req), .cfg_write_o(cfg_write), .cfg_addr_o(cfg_addr),
        .cfg_size_o(cfg_size), .cfg_wdata_o(cfg_wdata),
        .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; acc_size = 2'd2;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        p_qinit = qinit; p_qidx = qinit_idx; p_notify = notify; p_nidx = notify_idx;
        p_rst = dev_reset; p_rdy = drv_ready;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] cause, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; irq_cause = cause;
        @(negedge clk);
        acc_valid = 1'b0; irq_cause = '0;
        d = acc_rvalid ? acc_rdata : 32'hDEAD_BEEF;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 ready", 32'(acc_ready), 32'd1);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 pulses", {28'd0, qinit, notify, dev_reset, drv_ready}, 32'd0);
        rd(8'd4, 8'h00, v);  check("R1 guest", v, 32'd0);
        rd(8'd14, 8'h00, v); check("R1 sel", v, 32'd0);
        rd(8'd18, 8'h00, v); check("R1 status", v, 32'd0);
        rd(8'd19, 8'h00, v); check("R1 isr", v, 32'd0);
        rd(8'd8, 8'h00, v);  check("R1 pfn", v, 32'd0);
    endtask

    task automatic t_access_timing();
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'd12;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R12 rvalid after accept", 32'(acc_rvalid), 32'd1);
        check("R12 not ready in RESP", 32'(acc_ready), 32'd0);
        check("R5 qsize", acc_rdata, 32'd256);
        @(negedge clk);
        check("R12 rvalid one cycle", 32'(acc_rvalid), 32'd0);
    endtask

    task automatic t_features();
        logic [31:0] v;
        rd(8'd0, 8'h00, v); check("R2 host features", v, 32'h4100_0021);
        wr(8'd4, 32'h0000_0021); rd(8'd4, 8'h00, v); check("R3 as-is", v, 32'h0000_0021);
        wr(8'd4, 32'h4000_0020); rd(8'd4, 8'h00, v); check("R3 bad bit -> minimal", v, MINF);
        wr(8'd4, 32'h0000_0100); rd(8'd4, 8'h00, v); check("R3 unsupported -> full", v, 32'h0100_0021);
        wr(8'd4, 32'h0100_0001); rd(8'd4, 8'h00, v); check("R3 empty-note bit kept", v, 32'h0100_0001);
    endtask

    task automatic t_select_pages();
        logic [31:0] v;
        wr(8'd14, 32'd1); rd(8'd14, 8'h00, v); check("R4 select 1", v, 32'd1);
        wr(8'd14, 32'd2); rd(8'd14, 8'h00, v); check("R4 select 2 ignored", v, 32'd1);
        wr(8'd14, 32'h0001_0000); rd(8'd14, 8'h00, v); check("R4 low 16 used", v, 32'd0);
        wr(8'd8, 32'h0000_1234);
        check("R5 qinit pulse", 32'(p_qinit), 32'd1); check("R5 qinit idx0", 32'(p_qidx), 32'd0);
        wr(8'd14, 32'd1);
        check("R5 no qinit on select", 32'(p_qinit), 32'd0);
        wr(8'd8, 32'h0000_0055);
        check("R5 qinit idx1", 32'(p_qidx), 32'd1);
        rd(8'd8, 8'h00, v); check("R5 pfn q1", v, 32'h55);
        wr(8'd14, 32'd0); rd(8'd8, 8'h00, v); check("R5 pfn q0", v, 32'h1234);
    endtask

    task automatic t_notify();
        wr(8'd16, 32'd1);
        check("R8 notify live q1", 32'(p_notify), 32'd1); check("R8 notify idx", 32'(p_nidx), 32'd1);
        wr(8'd16, 32'd7);
        check("R8 notify out of range", 32'(p_notify), 32'd0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        wr(8'd18, 32'h01); check("R7 no ready without bit2", 32'(p_rdy), 32'd0);
        wr(8'd18, 32'h05); check("R7 ready on rise", 32'(p_rdy), 32'd1);
        wr(8'd18, 32'h07); check("R7 no ready when held", 32'(p_rdy), 32'd0);
        rd(8'd18, 8'h00, v); check("R7 status readback", v, 32'h07);
    endtask

    task automatic t_isr();
        logic [31:0] v;
        @(negedge clk); irq_cause = 8'h03; @(negedge clk); irq_cause = 8'h00;
        check("R9 irq raised", 32'(irq), 32'd1);
        rd(8'd19, 8'h00, v); check("R9 isr value", v, 32'h03);
        check("R9 irq dropped", 32'(irq), 32'd0);
        @(negedge clk); irq_cause = 8'h01; @(negedge clk); irq_cause = 8'h00;
        rd(8'd19, 8'h04, v); check("R9 read with new cause", v, 32'h01);
        check("R9 new cause pending", 32'(irq), 32'd1);
        rd(8'd19, 8'h00, v); check("R9 new cause value", v, 32'h04);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        @(negedge clk); irq_cause = 8'h10; @(negedge clk); irq_cause = 8'h00;
        wr(8'd14, 32'd1);
        wr(8'd18, 32'h00);
        check("R6 reset pulse on status 0", 32'(p_rst), 32'd1);
        check("R6 irq cleared", 32'(irq), 32'd0);
        rd(8'd4, 8'h00, v);  check("R6 guest cleared", v, 32'd0);
        rd(8'd14, 8'h00, v); check("R6 sel cleared", v, 32'd0);
        rd(8'd18, 8'h00, v); check("R6 status cleared", v, 32'd0);
        rd(8'd8, 8'h00, v);  check("R6 pfn q0 cleared", v, 32'd0);
        wr(8'd14, 32'd1); rd(8'd8, 8'h00, v); check("R6 pfn q1 cleared", v, 32'd0);
        wr(8'd16, 32'd1); check("R8 no notify on empty page", 32'(p_notify), 32'd0);
        wr(8'd8, 32'h77); wr(8'd4, 32'h21);
        wr(8'd8, 32'h0);
        check("R6 reset pulse on page 0", 32'(p_rst), 32'd1);
        check("R6 no qinit on page 0", 32'(p_qinit), 32'd0);
        rd(8'd4, 8'h00, v); check("R6 guest cleared by page 0", v, 32'd0);
    endtask

    task automatic t_unknown();
        logic [31:0] v;
        rd(8'd5, 8'h00, v); check("R11 unused read ones", v, 32'hFFFF_FFFF);
        rd(8'd17, 8'h00, v); check("R11 unused 17 ones", v, 32'hFFFF_FFFF);
        wr(8'd4, 32'h20);
        wr(8'd13, 32'h0);
        wr(8'd6, 32'h1);
        check("R11 unused write no reset", 32'(p_rst), 32'd0);
        rd(8'd4, 8'h00, v); check("R11 guest untouched", v, 32'h20);
    endtask

    task automatic t_config();
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 8'd22; acc_wdata = 32'hAB; acc_size = 2'd0;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 cfg req", 32'(cfg_req), 32'd1);
        check("R10 cfg addr", 32'(cfg_addr), 32'd2);
        check("R10 cfg write", 32'(cfg_write), 32'd1);
        check("R10 cfg size", 32'(cfg_size), 32'd0);
        @(negedge clk); @(negedge clk);
        check("R10 cfg held", {cfg_req, cfg_wdata[30:0]}, {1'b1, 31'hAB});
        check("R12 not ready while waiting", 32'(acc_ready), 32'd0);
        cfg_ack = 1'b1;
        @(negedge clk);
        cfg_ack = 1'b0;
        check("R10 write released", {30'd0, cfg_req, acc_rvalid}, 32'd0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'd24; acc_size = 2'd1;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 cfg read addr", 32'(cfg_addr), 32'd4);
        cfg_ack = 1'b1; cfg_rdata = 32'h0000_CAFE;
        @(negedge clk);
        cfg_ack = 1'b0; cfg_rdata = '0;
        check("R10 cfg read valid", 32'(acc_rvalid), 32'd1);
        check("R10 cfg read data", acc_rdata, 32'h0000_CAFE);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_access_timing();
        t_features();
        t_select_pages();
        t_notify();
        t_status();
        t_isr();
        t_soft_reset();
        t_unknown();
        t_config();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule